// File: doc/BRIEF.md
# Switch-Control Register Slave

This block is a two-wire serial bus slave (I2C compatible) that owns one 8-bit control word and drives it out in parallel as eight switch enables, one bit per switch, bit 7 first on the wire. A fast system clock oversamples the bus. Both bus lines are synchronised and then filtered, so that spikes shorter than a set number of system-clock cycles never reach the protocol logic.

The slave answers to a 7-bit address. Its upper five bits are a fixed prefix set by a parameter, default `10011`. Below that come the two strap inputs: strap bit 1, then strap bit 0 as the last address bit. After a matching address, a write stores every data byte that follows into the control word, so the word is updated once per byte until STOP. A read returns the live control word, MSB first, for as long as the master keeps acknowledging. The data line is open-drain: the block only ever asks for the line to be pulled low. Each committed byte raises a single-cycle update strobe.

Top module: `swreg_i2c_slave`

## Requirements
- R1: The slave acknowledges (pulls the data line low in the ninth clock pulse) an address byte whose upper seven bits equal {prefix, strap[1], strap[0]}. Bit 0 of that byte is R/W, with 0 = write and 1 = read.
- R2: In a write, a data byte sent MSB first appears on `sw_en_o` with its first bit on `sw_en_o[7]`, and the slave acknowledges that byte.
- R3: Every further data byte in the same write transaction updates `sw_en_o` again, with no new address byte.
- R4: In a read, the slave shifts out the current control word MSB first. While the master acknowledges, it sends the word again in the next byte.
- R5: After the master does not acknowledge a read byte, the slave stops driving the data line and stays released through STOP.
- R6: After an address that does not match, the slave acknowledges nothing and changes nothing until the next START, even if a later byte matches its own address.
- R7: `rst_ni` low clears `sw_en_o` to 0 at once, with no clock edge needed. A read after reset returns 0x00.
- R8: `upd_o` is high for exactly one system-clock cycle per committed byte, and `sw_en_o` never changes on a cycle without it.
- R9: A pulse on either bus line shorter than `FILT_CYC` system-clock cycles has no effect: an SCL spike is not counted as a bit, and an SDA spike while SCL is high is taken as neither START nor STOP.
- R10: A repeated START in the middle of a byte drops the partial byte and returns the slave to address reception.
- R11: A STOP in the middle of a data byte leaves `sw_en_o` unchanged and raises no update strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, at least 20x the bus clock |
| rst_ni | input | 1 | Asynchronous active-low clear |
| scl_i | input | 1 | Bus clock line |
| sda_i | input | 1 | Bus data line as seen on the wire |
| addr_strap_i | input | 2 | Low two address bits; bit 1 sits above bit 0 |
| sda_oe_o | output | 1 | 1 = pull the data line low |
| sw_en_o | output | 8 | Switch enables, one per bit |
| upd_o | output | 1 | One-cycle strobe when a byte is committed |

## Verification
The address walk drives every strap setting, a prefix mismatch and a strap mismatch. A wrong compare either acknowledges another device's address or loads a foreign byte into the switches. After a rejected address, the bench sends a byte that equals the slave's own address: a slave that re-armed too early would acknowledge it. A repeated START and a STOP are each placed in the middle of a byte. A design that kept the partial bits would load a shifted word, or raise a strobe with no complete byte. Spikes shorter than the filter window go on SCL during a data byte and on SDA while SCL is high. A weak filter would shift an extra bit into the word, or abort the byte through a false START.

// File: rtl/swr_pkg.sv
package swr_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned CNT_W  = 4;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_WR,
    ST_WR_ACK,
    ST_RD,
    ST_RD_ACK
  } xfer_state_e;
endpackage

// File: rtl/swr_line_filter.sv
module swr_line_filter #(
  parameter int unsigned FILT_CYC = 5,
  parameter bit          IDLE_VAL = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic line_i,
  output logic line_o
);
  localparam int unsigned CW = $clog2(FILT_CYC + 1);

  logic [1:0]    sync_q;
  logic [CW-1:0] cnt_q;
  logic          out_q;

  // output follows only after FILT_CYC consecutive differing samples
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= {2{IDLE_VAL}};
      cnt_q  <= '0;
      out_q  <= IDLE_VAL;
    end else begin
      sync_q <= {sync_q[0], line_i};
      if (sync_q[1] == out_q) begin
        cnt_q <= '0;
      end else if (cnt_q == CW'(FILT_CYC - 1)) begin
        out_q <= sync_q[1];
        cnt_q <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign line_o = out_q;

  // R9
  filt_cnt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q < CW'(FILT_CYC));

  // R9
  filt_out_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(out_q) |-> ($past(cnt_q) == CW'(FILT_CYC - 1)));
endmodule

// File: rtl/swr_bus_events.sv
module swr_bus_events (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic scl_q, sda_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
    end
  end

  assign scl_rise_o = scl_i & ~scl_q;
  assign scl_fall_o = ~scl_i & scl_q;
  // data edge counts as a condition only with the clock held high on both samples
  assign start_o    = scl_i & scl_q & sda_q & ~sda_i;
  assign stop_o     = scl_i & scl_q & ~sda_q & sda_i;
endmodule

// File: rtl/swr_xfer_fsm.sv
module swr_xfer_fsm
  import swr_pkg::*;
#(
  parameter logic [4:0] ADDR_PREFIX = 5'b10011
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_rise_i,
  input  logic              scl_fall_i,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic              sda_i,
  input  logic [1:0]        addr_strap_i,
  output logic              sda_oe_o,
  output logic [BYTE_W-1:0] sw_en_o,
  output logic              upd_o
);
  xfer_state_e       state_q;
  logic [CNT_W-1:0]  bit_cnt_q;
  logic [BYTE_W-1:0] rx_q, tx_q, word_q;
  logic              rw_q, mack_q, oe_q, upd_q;
  logic [6:0]        own_addr;
  logic              byte_done;

  assign own_addr  = {ADDR_PREFIX, addr_strap_i[1], addr_strap_i[0]};
  assign byte_done = (bit_cnt_q == CNT_W'(BYTE_W));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      bit_cnt_q <= '0;
      rx_q      <= '0;
      tx_q      <= '0;
      word_q    <= '0;
      rw_q      <= 1'b0;
      mack_q    <= 1'b0;
      oe_q      <= 1'b0;
      upd_q     <= 1'b0;
    end else begin
      upd_q <= 1'b0;
      if (start_i) begin
        state_q   <= ST_ADDR;
        bit_cnt_q <= '0;
        oe_q      <= 1'b0;
      end else if (stop_i) begin
        state_q <= ST_IDLE;
        oe_q    <= 1'b0;
      end else begin
        case (state_q)
          ST_ADDR: begin
            if (scl_rise_i) begin
              rx_q      <= {rx_q[BYTE_W-2:0], sda_i};
              bit_cnt_q <= bit_cnt_q + 1'b1;
            end else if (scl_fall_i && byte_done) begin
              if (rx_q[BYTE_W-1:1] == own_addr) begin
                rw_q    <= rx_q[0];
                oe_q    <= 1'b1;
                state_q <= ST_ADDR_ACK;
              end else begin
                state_q <= ST_IDLE;
              end
            end
          end
          ST_ADDR_ACK: begin
            if (scl_fall_i) begin
              bit_cnt_q <= '0;
              if (rw_q) begin
                tx_q    <= word_q;
                oe_q    <= ~word_q[BYTE_W-1];
                state_q <= ST_RD;
              end else begin
                oe_q    <= 1'b0;
                state_q <= ST_WR;
              end
            end
          end
          ST_WR: begin
            if (scl_rise_i) begin
              rx_q      <= {rx_q[BYTE_W-2:0], sda_i};
              bit_cnt_q <= bit_cnt_q + 1'b1;
            end else if (scl_fall_i && byte_done) begin
              word_q  <= rx_q;
              upd_q   <= 1'b1;
              oe_q    <= 1'b1;
              state_q <= ST_WR_ACK;
            end
          end
          ST_WR_ACK: begin
            if (scl_fall_i) begin
              oe_q      <= 1'b0;
              bit_cnt_q <= '0;
              state_q   <= ST_WR;
            end
          end
          ST_RD: begin
            if (scl_rise_i) begin
              bit_cnt_q <= bit_cnt_q + 1'b1;
            end else if (scl_fall_i) begin
              if (byte_done) begin
                oe_q    <= 1'b0;
                state_q <= ST_RD_ACK;
              end else begin
                tx_q <= {tx_q[BYTE_W-2:0], 1'b0};
                oe_q <= ~tx_q[BYTE_W-2];
              end
            end
          end
          ST_RD_ACK: begin
            if (scl_rise_i) begin
              mack_q <= ~sda_i;
            end else if (scl_fall_i) begin
              if (mack_q) begin
                tx_q      <= word_q;
                oe_q      <= ~word_q[BYTE_W-1];
                bit_cnt_q <= '0;
                state_q   <= ST_RD;
              end else begin
                state_q <= ST_IDLE;
              end
            end
          end
          default: state_q <= ST_IDLE;
        endcase
      end
    end
  end

  assign sda_oe_o = oe_q;
  assign sw_en_o  = word_q;
  assign upd_o    = upd_q;

  // R8
  upd_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_q |=> !upd_q);

  // R8
  word_strobe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(word_q) |-> upd_q);

  // R5
  idle_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE) |-> !oe_q);

  // R1
  ack_match_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(state_q) == ST_ADDR && state_q == ST_ADDR_ACK)
      |-> ($past(rx_q[BYTE_W-1:1]) == $past(own_addr)));

  // R10
  restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> (state_q == ST_ADDR && bit_cnt_q == '0 && !oe_q));
endmodule

// File: rtl/swreg_i2c_slave.sv
module swreg_i2c_slave
  import swr_pkg::*;
#(
  parameter logic [4:0]  ADDR_PREFIX = 5'b10011,
  parameter int unsigned FILT_CYC    = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic [1:0]        addr_strap_i,
  output logic              sda_oe_o,
  output logic [BYTE_W-1:0] sw_en_o,
  output logic              upd_o
);
  localparam int unsigned N_LINES = 2;

  logic [N_LINES-1:0] raw_lines, clean_lines;
  logic scl_rise, scl_fall, start_ev, stop_ev;

  assign raw_lines = {scl_i, sda_i};

  for (genvar g = 0; g < N_LINES; g++) begin : g_filt
    swr_line_filter #(
      .FILT_CYC (FILT_CYC),
      .IDLE_VAL (1'b1)
    ) u_filt (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .line_i (raw_lines[g]),
      .line_o (clean_lines[g])
    );
  end

  swr_bus_events u_events (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .scl_i      (clean_lines[1]),
    .sda_i      (clean_lines[0]),
    .scl_rise_o (scl_rise),
    .scl_fall_o (scl_fall),
    .start_o    (start_ev),
    .stop_o     (stop_ev)
  );

  swr_xfer_fsm #(
    .ADDR_PREFIX (ADDR_PREFIX)
  ) u_fsm (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .scl_rise_i   (scl_rise),
    .scl_fall_i   (scl_fall),
    .start_i      (start_ev),
    .stop_i       (stop_ev),
    .sda_i        (clean_lines[0]),
    .addr_strap_i (addr_strap_i),
    .sda_oe_o     (sda_oe_o),
    .sw_en_o      (sw_en_o),
    .upd_o        (upd_o)
  );
endmodule

// File: tb/swreg_i2c_slave_tb.sv
module swreg_i2c_slave_tb;
  localparam int CLK_PERIOD = 10;
  localparam int Q = 20;

  // {strap[1:0], addr7, data8, expect_ack, expect_sw8}
  localparam int NV = 7;
  localparam logic [25:0] VEC [NV] = '{
    {2'b00, 7'h4C, 8'hA5, 1'b1, 8'hA5},
    {2'b11, 7'h4F, 8'h3C, 1'b1, 8'h3C},
    {2'b10, 7'h4E, 8'hFF, 1'b1, 8'hFF},
    {2'b01, 7'h4D, 8'h00, 1'b1, 8'h00},
    {2'b00, 7'h4D, 8'h77, 1'b0, 8'h00},
    {2'b01, 7'h4D, 8'h81, 1'b1, 8'h81},
    {2'b01, 7'h45, 8'h12, 1'b0, 8'h81}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic [1:0] strap = 2'b00;
  logic sda_oe;
  logic [7:0] sw_en;
  logic upd;
  logic sda_bus;

  int total = 0;
  int bad = 0;
  int upd_cnt = 0;
  int upd_long = 0;
  logic upd_prev = 1'b0;

  assign sda_bus = sda_m & ~sda_oe;

  always #(CLK_PERIOD / 2) clk = ~clk;

  swreg_i2c_slave u_dut (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .scl_i        (scl_m),
    .sda_i        (sda_bus),
    .addr_strap_i (strap),
    .sda_oe_o     (sda_oe),
    .sw_en_o      (sw_en),
    .upd_o        (upd)
  );

  always @(negedge clk) begin
    if (upd) upd_cnt++;
    if (upd && upd_prev) upd_long++;
    upd_prev = upd;
  end

  task automatic wclk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string tag, input int got, input int exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
    end
  endtask

  task automatic bus_start();
    sda_m = 1'b1; wclk(Q);
    scl_m = 1'b1; wclk(Q);
    sda_m = 1'b0; wclk(Q);
    scl_m = 1'b0; wclk(Q);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wclk(Q);
    scl_m = 1'b1; wclk(Q);
    sda_m = 1'b1; wclk(2 * Q);
  endtask

  task automatic bus_bit(input logic b, input logic glitch, output logic smp);
    sda_m = b; wclk(Q);
    scl_m = 1'b1; wclk(Q / 2);
    if (glitch && b) begin
      sda_m = 1'b0; wclk(3);
      sda_m = 1'b1; wclk(Q / 2 - 3);
    end else begin
      wclk(Q / 2);
    end
    smp = sda_bus;
    wclk(Q);
    scl_m = 1'b0; wclk(Q);
  endtask

  task automatic send_byte(input logic [7:0] d, input logic [7:0] gmask, output logic ack);
    logic s;
    for (int i = 7; i >= 0; i--) bus_bit(d[i], gmask[i], s);
    bus_bit(1'b1, 1'b0, s);
    ack = ~s;
  endtask

  task automatic recv_byte(input logic mack, output logic [7:0] d);
    logic s;
    for (int i = 7; i >= 0; i--) begin
      bus_bit(1'b1, 1'b0, s);
      d[i] = s;
    end
    bus_bit(~mack, 1'b0, s);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic ack;
    logic [7:0] rd;
    int u0;

    wclk(5);
    // R7 reset state
    check("R7 reset sw_en", sw_en, 8'h00);
    check("R7 reset sda_oe", sda_oe, 0);
    check("R8 reset upd", upd, 0);
    rst_n = 1'b1;
    wclk(10);

    // R1 R2 R6: table walk
    for (int v = 0; v < NV; v++) begin
      strap = VEC[v][25:24];
      wclk(5);
      bus_start();
      send_byte({VEC[v][23:17], 1'b0}, 8'h00, ack);
      check($sformatf("R1 addr ack vec%0d", v), ack, VEC[v][8]);
      send_byte(VEC[v][16:9], 8'h00, ack);
      bus_stop();
      check($sformatf("R2 sw_en vec%0d", v), sw_en, VEC[v][7:0]);
    end

    // R6: after mismatch, own-address byte is still ignored
    strap = 2'b00;
    u0 = upd_cnt;
    bus_start();
    send_byte(8'h9E, 8'h00, ack);
    check("R6 mismatch nack", ack, 0);
    send_byte(8'h98, 8'h00, ack);
    check("R6 own byte ignored", ack, 0);
    send_byte(8'hEE, 8'h00, ack);
    bus_stop();
    check("R6 sw unchanged", sw_en, 8'h81);
    check("R6 no strobe", upd_cnt - u0, 0);

    // R3: streamed bytes each update
    u0 = upd_cnt;
    bus_start();
    send_byte(8'h98, 8'h00, ack);
    send_byte(8'h11, 8'h00, ack);
    check("R3 byte1", sw_en, 8'h11);
    check("R2 data ack", ack, 1);
    send_byte(8'h22, 8'h00, ack);
    check("R3 byte2", sw_en, 8'h22);
    send_byte(8'h33, 8'h00, ack);
    check("R3 byte3", sw_en, 8'h33);
    bus_stop();
    check("R8 strobe count", upd_cnt - u0, 3);

    // R4 R5: read twice then nack
    bus_start();
    send_byte(8'hC3 ^ 8'hC3 ^ 8'h98, 8'h00, ack);
    send_byte(8'hC3, 8'h00, ack);
    bus_stop();
    bus_start();
    send_byte(8'h99, 8'h00, ack);
    check("R1 read addr ack", ack, 1);
    recv_byte(1'b1, rd);
    check("R4 read first", rd, 8'hC3);
    recv_byte(1'b0, rd);
    check("R4 read repeat", rd, 8'hC3);
    wclk(Q / 2);
    check("R5 released after nack", sda_oe, 0);
    bus_stop();
    check("R5 released after stop", sda_oe, 0);

    // R10: repeated start mid-byte
    u0 = upd_cnt;
    bus_start();
    send_byte(8'h98, 8'h00, ack);
    for (int i = 0; i < 4; i++) bus_bit(1'b1, 1'b0, ack);
    bus_start();
    send_byte(8'h98, 8'h00, ack);
    check("R10 re-addressed ack", ack, 1);
    send_byte(8'h5A, 8'h00, ack);
    bus_stop();
    check("R10 sw_en", sw_en, 8'h5A);
    check("R10 one strobe", upd_cnt - u0, 1);

    // R11: stop mid-byte
    u0 = upd_cnt;
    bus_start();
    send_byte(8'h98, 8'h00, ack);
    for (int i = 0; i < 5; i++) bus_bit(1'b0, 1'b0, ack);
    bus_stop();
    check("R11 sw unchanged", sw_en, 8'h5A);
    check("R11 no strobe", upd_cnt - u0, 0);

    // R9: scl spike during low phase, sda spikes while scl high
    bus_start();
    send_byte(8'h98, 8'h00, ack);
    sda_m = 1'b1; wclk(5);
    scl_m = 1'b1; wclk(3);
    scl_m = 1'b0; wclk(5);
    send_byte(8'h96, 8'h00, ack);
    check("R9 scl spike", sw_en, 8'h96);
    send_byte(8'hB7, 8'hFF, ack);
    check("R9 sda spike", sw_en, 8'hB7);
    bus_stop();

    // R7: asynchronous clear, then read back zero
    rst_n = 1'b0;
    #1;
    check("R7 async clear", sw_en, 8'h00);
    wclk(3);
    rst_n = 1'b1;
    wclk(5);
    bus_start();
    send_byte(8'h99, 8'h00, ack);
    recv_byte(1'b0, rd);
    bus_stop();
    check("R7 read after reset", rd, 8'h00);

    check("R8 strobe width", upd_long, 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule